// File: doc/BRIEF.md
# Functional Unit Pool Allocator

This block owns the busy state of a fixed group of execution units in an out-of-order core and hands them out by operation class. A static capability table, given as a parameter, records which classes each unit can execute. Each class has its own rotating search order over the unit indices that support it. A start pointer, kept per class, marks where the next search for that class begins. The pointer moves past every unit that a search examines, so units that were just used fall to the back of that class's order.

One request per cycle names a class. The answer comes back in the same cycle as a 2-bit status and a unit index. The status is `00` for a grant, `01` when every capable unit is busy, and `10` when no unit in the pool can execute the class. The allocator sets busy bits and never clears them by itself. The execute stage returns units through a free mask. The busy bits of all units in the mask are cleared together at the clock edge that ends the cycle, so a unit being freed cannot be granted in that same cycle.

A second, independent class input reads out two values for that class: the largest operation latency and the largest issue latency among the units that support it. The configuration must give every unit either an issue latency of one or an issue latency equal to its operation latency.

Top module: `fu_pool_alloc`

## Requirements
- R1: After synchronous reset, no unit is busy and every class pointer is 0, so the first request for a class is granted the lowest-numbered unit that supports it.
- R2: A valid request for a class that no unit supports returns status `10` with unit index 0 and changes no busy bit and no pointer. The status code `11` never appears.
- R3: When the class is supported but every unit that supports it is busy, status `01` is returned with unit index 0. No busy bit changes.
- R4: A grant returns status `00` and the index of a free unit that supports the class. That unit's busy bit is set at the next edge, so it is not granted to any class until it is freed. This holds even when the unit is shared between classes.
- R5: The search visits unit indices in ascending order, wrapping from the last unit back to 0. It starts at the class's pointer and skips units that are incapable or busy. After a grant, that class's pointer moves to the index after the granted unit, wrapping to 0.
- R6: Setting bit u of `free_mask` clears unit u's busy bit at the next clock edge. A unit that is busy during the cycle in which it is freed is not granted in that cycle.
- R7: Free bits for units that are not busy have no effect. A cycle with `req_valid` low changes no busy bit and no pointer, even though the response outputs still show what a request would get.
- R8: `max_op_lat` gives the largest operation latency among units that support `lat_class`, or 0 when none does.
- R9: `max_iss_lat` gives the largest issue latency among units that support `lat_class`, or 0 when none does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present this cycle |
| req_class | input | CLS_W (3) | Operation class requested |
| free_mask | input | NUM_UNITS (8) | One bit per unit to release at the end of the cycle |
| grant_status | output | 2 | 00 granted, 01 all capable busy, 10 class unsupported |
| grant_unit | output | UNIT_W (3) | Granted unit index, 0 when not granted |
| lat_class | input | CLS_W (3) | Class for the latency lookup |
| max_op_lat | output | LAT_W (4) | Largest operation latency for lat_class |
| max_iss_lat | output | LAT_W (4) | Largest issue latency for lat_class |

## Verification
The bench builds the block with its default configuration of eight units and eight classes. Units 0–2 share class 0, unit 2 also serves class 2, units 3 and 5 each serve two classes, and class 7 is supported by no unit. Sharing units between classes lets a grant in one class produce a "busy" answer in another. Because the unsupported class is present, the `10` code can be reached. With only eight units, the pointer of every class wraps many times during a long pseudo-random run of requests and multi-bit frees. A model in the bench follows the stated search rule every cycle, and all eight latency lookups are swept.

// File: rtl/fupa_pkg.sv
package fupa_pkg;
    typedef enum logic [1:0] {
        ST_GRANT    = 2'b00,
        ST_ALL_BUSY = 2'b01,
        ST_NO_CAP   = 2'b10
    } fupa_status_e;
endpackage

// File: rtl/fupa_rotate_pick.sv
module fupa_rotate_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] start,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (!hit && cand[(int'(start) + k) % N]) begin
                hit = 1'b1;
                idx = IW'((int'(start) + k) % N);
            end
        end
    end
endmodule

// File: rtl/fupa_busy_track.sv
module fupa_busy_track #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [IW-1:0] take_idx,
    input  logic [N-1:0]  release_mask,
    output logic [N-1:0]  busy
);
    logic [N-1:0] take_vec;

    always_comb begin
        take_vec = '0;
        if (take) take_vec[take_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) busy <= '0;
        else     busy <= (busy & ~release_mask) | take_vec;
    end
endmodule

// File: rtl/fupa_lat_table.sv
module fupa_lat_table #(
    parameter int N     = 8,
    parameter int C     = 8,
    parameter int LAT_W = 4,
    parameter logic [N-1:0][C-1:0]     CAP     = '0,
    parameter logic [N-1:0][LAT_W-1:0] OP_LAT  = '0,
    parameter logic [N-1:0][LAT_W-1:0] ISS_LAT = '0,
    localparam int CW = $clog2(C)
) (
    input  logic [CW-1:0]    cls,
    output logic [LAT_W-1:0] op_max,
    output logic [LAT_W-1:0] iss_max
);
    function automatic logic [LAT_W-1:0] col_max(int c, logic [N-1:0][LAT_W-1:0] tbl);
        logic [LAT_W-1:0] m;
        m = '0;
        for (int u = 0; u < N; u++)
            if (CAP[u][c] && tbl[u] > m) m = tbl[u];
        return m;
    endfunction

    logic [C-1:0][LAT_W-1:0] op_tab;
    logic [C-1:0][LAT_W-1:0] iss_tab;

    for (genvar c = 0; c < C; c++) begin : g_cls
        assign op_tab[c]  = col_max(c, OP_LAT);
        assign iss_tab[c] = col_max(c, ISS_LAT);
    end

    always_comb begin
        op_max  = '0;
        iss_max = '0;
        if (int'(cls) < C) begin
            op_max  = op_tab[cls];
            iss_max = iss_tab[cls];
        end
    end
endmodule

// File: rtl/fu_pool_alloc.sv
module fu_pool_alloc #(
    parameter int NUM_UNITS   = 8,
    parameter int NUM_CLASSES = 8,
    parameter int LAT_W       = 4,
    parameter logic [NUM_UNITS-1:0][NUM_CLASSES-1:0] CAP     = 64'h40_20_30_08_0C_05_03_03,
    parameter logic [NUM_UNITS-1:0][LAT_W-1:0]       OP_LAT  = 32'h2956_4321,
    parameter logic [NUM_UNITS-1:0][LAT_W-1:0]       ISS_LAT = 32'h2916_1311,
    localparam int UNIT_W = $clog2(NUM_UNITS),
    localparam int CLS_W  = $clog2(NUM_CLASSES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [CLS_W-1:0]     req_class,
    input  logic [NUM_UNITS-1:0] free_mask,
    output logic [1:0]           grant_status,
    output logic [UNIT_W-1:0]    grant_unit,
    input  logic [CLS_W-1:0]     lat_class,
    output logic [LAT_W-1:0]     max_op_lat,
    output logic [LAT_W-1:0]     max_iss_lat
);
    import fupa_pkg::*;

    logic [NUM_UNITS-1:0]              busy_q;
    logic [NUM_CLASSES-1:0][UNIT_W-1:0] head_q;
    logic [NUM_UNITS-1:0]              cap_col;
    logic [UNIT_W-1:0]                 start_idx;
    logic                              pick_hit;
    logic [UNIT_W-1:0]                 pick_idx;
    logic                              grant_en;
    fupa_status_e                      status;

    always_comb begin
        cap_col   = '0;
        start_idx = '0;
        if (int'(req_class) < NUM_CLASSES) begin
            start_idx = head_q[req_class];
            for (int u = 0; u < NUM_UNITS; u++) cap_col[u] = CAP[u][req_class];
        end
    end

    fupa_rotate_pick #(.N(NUM_UNITS)) u_pick (
        .cand  (cap_col & ~busy_q),
        .start (start_idx),
        .hit   (pick_hit),
        .idx   (pick_idx)
    );

    always_comb begin
        unique case ({|cap_col, pick_hit})
            2'b11:   status = ST_GRANT;
            2'b10:   status = ST_ALL_BUSY;
            default: status = ST_NO_CAP;
        endcase
        grant_status = status;
        grant_unit   = (status == ST_GRANT) ? pick_idx : '0;
        grant_en     = req_valid && (status == ST_GRANT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
        end else if (grant_en) begin
            head_q[req_class] <= (int'(pick_idx) == NUM_UNITS - 1) ? '0 : pick_idx + 1'b1;
        end
    end

    fupa_busy_track #(.N(NUM_UNITS)) u_busy (
        .clk          (clk),
        .rst          (rst),
        .take         (grant_en),
        .take_idx     (pick_idx),
        .release_mask (free_mask),
        .busy         (busy_q)
    );

    fupa_lat_table #(
        .N(NUM_UNITS), .C(NUM_CLASSES), .LAT_W(LAT_W),
        .CAP(CAP), .OP_LAT(OP_LAT), .ISS_LAT(ISS_LAT)
    ) u_lat (
        .cls     (lat_class),
        .op_max  (max_op_lat),
        .iss_max (max_iss_lat)
    );
endmodule

// File: rtl/fupa_checker.sv
module fupa_checker #(
    parameter int N = 8,
    parameter int C = 8,
    parameter logic [N-1:0][C-1:0] CAP = '0,
    localparam int IW = $clog2(N),
    localparam int CW = $clog2(C)
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [CW-1:0] req_class,
    input logic [N-1:0]  free_mask,
    input logic [1:0]    grant_status,
    input logic [IW-1:0] grant_unit,
    input logic [N-1:0]  busy_q
);
    function automatic logic [N-1:0] col(logic [CW-1:0] c);
        logic [N-1:0] v;
        v = '0;
        if (int'(c) < C)
            for (int u = 0; u < N; u++) v[u] = CAP[u][c];
        return v;
    endfunction

    logic granting;
    assign granting = req_valid && grant_status == 2'b00;

    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (rst)
        grant_status != 2'b11); // R2

    AST_ALL_BUSY_REAL: assert property (@(posedge clk) disable iff (rst)
        grant_status == 2'b01 |-> (col(req_class) != '0) && ((col(req_class) & ~busy_q) == '0)); // R3

    AST_GRANT_CAPABLE: assert property (@(posedge clk) disable iff (rst)
        granting |-> col(req_class)[grant_unit] && !busy_q[grant_unit]); // R4

    AST_GRANT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        granting |=> busy_q[$past(grant_unit)]); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !req_valid && free_mask == '0 |=> $stable(busy_q)); // R7

    for (genvar u = 0; u < N; u++) begin : g_unit
        AST_FREE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            free_mask[u] && !(granting && int'(grant_unit) == u) |=> !busy_q[u]); // R6
    end
endmodule

bind fu_pool_alloc fupa_checker #(.N(NUM_UNITS), .C(NUM_CLASSES), .CAP(CAP)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
    .free_mask(free_mask), .grant_status(grant_status), .grant_unit(grant_unit),
    .busy_q(busy_q)
);

// File: tb/sim_fu_pool_alloc.sv
module sim_fu_pool_alloc;
    localparam logic [63:0] CAPB = 64'h40_20_30_08_0C_05_03_03;
    localparam logic [31:0] OPB  = 32'h2956_4321;
    localparam logic [31:0] ISB  = 32'h2916_1311;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_class = '0;
    logic [7:0] free_mask = '0;
    logic [1:0] grant_status;
    logic [2:0] grant_unit;
    logic [2:0] lat_class = '0;
    logic [3:0] max_op_lat;
    logic [3:0] max_iss_lat;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit mbusy[8];
    int mhead[8];
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    fu_pool_alloc #(.CAP(CAPB), .OP_LAT(OPB), .ISS_LAT(ISB)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
        .free_mask(free_mask), .grant_status(grant_status), .grant_unit(grant_unit),
        .lat_class(lat_class), .max_op_lat(max_op_lat), .max_iss_lat(max_iss_lat)
    );

    function automatic bit cap(int u, int c);
        return CAPB[u*8 + c];
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // drive one cycle, compare against the bench model, then advance the model
    task automatic step(bit v, int c, logic [7:0] fm, string tag);
        int es, eu;
        string t;
        @(negedge clk);
        req_valid = v; req_class = 3'(c); free_mask = fm;
        #1;
        es = 2; eu = 0;
        for (int u = 0; u < 8; u++) if (cap(u, c)) es = 1;
        if (es == 1) begin
            for (int k = 0; k < 8; k++) begin
                if (es == 1 && cap((mhead[c] + k) % 8, c) && !mbusy[(mhead[c] + k) % 8]) begin
                    es = 0; eu = (mhead[c] + k) % 8;
                end
            end
        end
        t = (tag != "") ? tag : (es == 2 ? "R2" : (es == 1 ? "R3" : "R5"));
        chk(grant_status == 2'(es), {t, " status"}, grant_status, es);
        chk(grant_unit == 3'(eu), {t, " unit"}, grant_unit, eu);
        for (int u = 0; u < 8; u++) if (fm[u]) mbusy[u] = 1'b0;
        if (v && es == 0) begin
            mbusy[eu] = 1'b1;
            mhead[c] = (eu + 1) % 8;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++; fails++;
                $display("FAIL watchdog: got %0d expected %0d", cycles, 100000);
                finish_run();
            end
        end
    end

    initial begin
        for (int u = 0; u < 8; u++) begin mbusy[u] = 0; mhead[u] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(1, 0, 8'h00, "R1");   // first grant for class 0 is unit 0
        step(1, 0, 8'h00, "R5");   // pointer moved on: unit 1
        step(1, 0, 8'h00, "R5");   // unit 2
        step(1, 0, 8'h00, "R3");   // units 0..2 busy
        step(1, 7, 8'h00, "R2");   // class 7 has no unit
        step(1, 2, 8'h00, "R4");   // unit 2 taken via class 0, so unit 3
        step(1, 2, 8'h00, "R3");
        step(1, 0, 8'h02, "R6");   // unit 1 freed this cycle: still none
        step(1, 0, 8'h00, "R6");   // now unit 1 granted
        step(0, 3, 8'h40, "R7");   // idle free of unit 6, no request
        step(1, 3, 8'h00, "R7");   // unit 4 still free after the idle cycle
        step(1, 5, 8'h00, "R7");   // unit 5 granted; unit 6 free was harmless
        step(1, 5, 8'h00, "R7");   // unit 6 granted
        for (int c = 0; c < 8; c++) begin
            int eo, ei;
            eo = 0; ei = 0;
            for (int u = 0; u < 8; u++) if (cap(u, c)) begin
                if (int'(OPB[u*4 +: 4]) > eo) eo = int'(OPB[u*4 +: 4]);
                if (int'(ISB[u*4 +: 4]) > ei) ei = int'(ISB[u*4 +: 4]);
            end
            lat_class = 3'(c);
            #1;
            chk(max_op_lat == 4'(eo), "R8 op latency", max_op_lat, eo);
            chk(max_iss_lat == 4'(ei), "R9 issue latency", max_iss_lat, ei);
        end
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r = lfsr;
            step(r[0] | r[1], int'(r[4:2]), r[15:8] & {r[7:5], r[12:8]}, "");
        end
        step(0, 0, 8'hFF, "R6");
        step(1, 6, 8'h00, "R1");
        finish_run();
    end
endmodule